// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes write frames from a slow three-wire serial port (a frame strobe, a serial clock and a data line) and stores them in a bank of thirteen 10-bit registers. Twelve of the registers hold channel codes that drive the outputs directly. The thirteenth is a control register. When it holds one particular code, the block raises an override flag that tells downstream logic to use the stored codes whatever level the external select pin has. Each frame also carries a bit that picks an internal or an external oscillator, and that choice is held as a flag.

All three serial pins are asynchronous to the system clock. They pass through two-flop synchronisers, and edges are found in the system clock domain. While the strobe is low, data is shifted in on each serial clock rise. On the strobe rise, the shifted word is checked and then committed. Frames that are too short are dropped, and in frames that are too long only the last 17 bits count.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset, all twelve channel codes read 0, the oscillator flag is 0 and the override flag is 0.
- R2: A frame of exactly 17 bits is sent first bit d0 to last bit d16 and is committed on the strobe rise. d2..d6 give the register address (d2 is the MSB) and d7..d16 give the 10-bit data (d7 is the MSB). Address n in 0..11 updates channel code n on bits [10n+9:10n] of the channel output bus.
- R3: Channel codes and flags do not change while bits are being shifted in and the strobe is still low.
- R4: A frame of fewer than 17 bits during one strobe-low period stores nothing and leaves all outputs unchanged.
- R5: A frame of more than 17 bits commits using only its final 17 bits.
- R6: An accepted frame loads d1 into the oscillator flag (0 selects the internal oscillator, 1 selects an external clock).
- R7: A frame whose test bit d0 is 1 is ignored: no code and no flag changes.
- R8: A frame whose address is in 13..31 is ignored: no code and no flag changes.
- R9: The override flag is 1 exactly while control register 12 holds 10'h2A0. Writing any other value to address 12 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| latch_in | input | 1 | Frame strobe; low while shifting, rising edge commits |
| sclk_in | input | 1 | Serial clock; data sampled on its rising edge |
| sdin_in | input | 1 | Serial data, first bit d0 |
| chan_codes_o | output | 120 | Twelve 10-bit channel codes, channel n at [10n+9:10n] |
| ext_osc_o | output | 1 | Oscillator mode flag, 1 = external clock |
| override_o | output | 1 | High while control register holds the override code |

## Verification
The assertions assume that the serial pins move slowly compared with the system clock, so that every serial clock high and low phase and every strobe level lasts at least a few system cycles after synchronisation. They also assume that the data line is stable before each serial clock rise and that the serial clock never rises while the strobe is high. The bench keeps every serial phase at four system cycles and changes the data line only while the serial clock is low. It lets the strobe go high only after the last serial clock fall, so each assumed ordering is met with margin.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int FRAME_LEN = 17;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 10;
  localparam int NUM_CHAN  = 12;
  localparam int NUM_REGS  = NUM_CHAN + 1;
  localparam int CTRL_ADDR = NUM_CHAN;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [DATA_W-1:0] OVR_CODE = 10'h2A0;

  typedef logic [FRAME_LEN-1:0] frame_t;
  typedef logic [ADDR_W-1:0]    addr_t;
  typedef logic [DATA_W-1:0]    data_t;

  // first bit shifted in ends up at the top of the word
  function automatic logic frame_test(frame_t f);
    return f[FRAME_LEN-1];
  endfunction

  function automatic logic frame_osc(frame_t f);
    return f[FRAME_LEN-2];
  endfunction

  function automatic addr_t frame_addr(frame_t f);
    return f[DATA_W+ADDR_W-1:DATA_W];
  endfunction

  function automatic data_t frame_data(frame_t f);
    return f[DATA_W-1:0];
  endfunction

  function automatic logic addr_ok(addr_t a);
    return int'(a) < NUM_REGS;
  endfunction

  function automatic logic is_override(data_t d);
    return d == OVR_CODE;
  endfunction
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_lane
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/srl_edge.sv
module srl_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end
  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise[g] = lvl[g] & ~prev[g];
  end
endmodule

// File: rtl/srl_shifter.sv
module srl_shifter
  import srl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             hold_clr,
  input  logic             bit_in,
  output frame_t           frame,
  output logic [CNT_W-1:0] bit_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else begin
      if (shift_en) frame <= {frame[FRAME_LEN-2:0], bit_in};
      if (hold_clr) bit_cnt <= '0;
      else if (shift_en && bit_cnt != CNT_W'(FRAME_LEN)) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srl_regbank.sv
module srl_regbank
  import srl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  addr_t                      wr_addr,
  input  data_t                      wr_data,
  input  logic                       wr_osc,
  output logic [NUM_CHAN*DATA_W-1:0] chan_codes,
  output data_t                      ctrl_reg,
  output logic                       ext_osc
);
  data_t regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))     regs[g] <= wr_data;
    end
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_out
    assign chan_codes[c*DATA_W +: DATA_W] = regs[c];
  end
  assign ctrl_reg = regs[CTRL_ADDR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ext_osc <= 1'b0;
    else if (wr_en) ext_osc <= wr_osc;
  end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import srl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       latch_in,
  input  logic                       sclk_in,
  input  logic                       sdin_in,
  output logic [NUM_CHAN*DATA_W-1:0] chan_codes_o,
  output logic                       ext_osc_o,
  output logic                       override_o
);
  logic [2:0]       pins_s;
  logic [1:0]       pin_rise;
  logic             latch_s, sdin_s;
  logic             latch_rise, sclk_rise;
  logic             shift_en, frame_full, commit_fire;
  frame_t           frame;
  logic [CNT_W-1:0] bit_cnt;
  data_t            ctrl_reg;

  srl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({sdin_in, sclk_in, latch_in}),
    .dout(pins_s)
  );

  srl_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl(pins_s[1:0]),
    .rise(pin_rise)
  );

  assign latch_s    = pins_s[0];
  assign sdin_s     = pins_s[2];
  assign latch_rise = pin_rise[0];
  assign sclk_rise  = pin_rise[1];
  assign shift_en   = sclk_rise & ~latch_s;

  srl_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_en),
    .hold_clr(latch_s),
    .bit_in(sdin_s),
    .frame(frame),
    .bit_cnt(bit_cnt)
  );

  // bit_cnt still holds the count of the low period in the strobe-rise cycle
  assign frame_full  = (bit_cnt == CNT_W'(FRAME_LEN));
  assign commit_fire = latch_rise & frame_full & ~frame_test(frame)
                     & addr_ok(frame_addr(frame));

  srl_regbank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit_fire),
    .wr_addr(frame_addr(frame)),
    .wr_data(frame_data(frame)),
    .wr_osc(frame_osc(frame)),
    .chan_codes(chan_codes_o),
    .ctrl_reg(ctrl_reg),
    .ext_osc(ext_osc_o)
  );

  assign override_o = is_override(ctrl_reg);
endmodule

// File: rtl/srl_checker.sv
module srl_checker
  import srl_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       latch_rise,
  input logic                       commit_fire,
  input frame_t                     frame,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic [NUM_CHAN*DATA_W-1:0] chan_codes,
  input logic                       ext_osc,
  input logic                       override
);
  function automatic data_t chan_at(logic [NUM_CHAN*DATA_W-1:0] v, addr_t a);
    return v[int'(a)*DATA_W +: DATA_W];
  endfunction

  logic in_chan, ctrl_hit;
  assign in_chan  = int'(frame_addr(frame)) < NUM_CHAN;
  assign ctrl_hit = frame_addr(frame) == ADDR_W'(CTRL_ADDR);

  p_cnt_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= FRAME_LEN);

  p_hold_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(chan_codes) && $stable(ext_osc));

  p_short_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rise && int'(bit_cnt) != FRAME_LEN |=> $stable(chan_codes) && $stable(ext_osc));

  p_test_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rise && frame_test(frame) |=> $stable(chan_codes) && $stable(ext_osc));

  p_bad_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rise && !addr_ok(frame_addr(frame)) |=> $stable(chan_codes) && $stable(ext_osc));

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire && in_chan |=>
      chan_at(chan_codes, $past(frame_addr(frame))) == $past(frame_data(frame)));

  p_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> ext_osc == $past(frame_osc(frame)));

  p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire && ctrl_hit && frame_data(frame) == OVR_CODE |=> override);

  p_ovr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire && ctrl_hit && frame_data(frame) != OVR_CODE |=> !override);
endmodule

bind serial_reg_loader srl_checker i_chk (
  .clk(clk),
  .rst_n(rst_n),
  .latch_rise(latch_rise),
  .commit_fire(commit_fire),
  .frame(frame),
  .bit_cnt(bit_cnt),
  .chan_codes(chan_codes_o),
  .ext_osc(ext_osc_o),
  .override(override_o)
);

// File: tb/test_serial_reg_loader.sv
module test_serial_reg_loader;
  localparam int NCH = 12;
  localparam int DW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch_in = 1'b1, sclk_in = 1'b0, sdin_in = 1'b0;
  logic [NCH*DW-1:0] chan_codes_o;
  logic ext_osc_o, override_o;

  always #4 clk = ~clk;

  serial_reg_loader i_serial_reg_loader (
    .clk(clk), .rst_n(rst_n),
    .latch_in(latch_in), .sclk_in(sclk_in), .sdin_in(sdin_in),
    .chan_codes_o(chan_codes_o), .ext_osc_o(ext_osc_o), .override_o(override_o)
  );

  typedef struct {
    logic [NCH*DW-1:0] codes;
    logic              osc;
    logic              ovr;
    string             tag;
  } exp_t;

  exp_t q[$];
  logic [DW-1:0] model [13];
  logic model_osc = 1'b0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic exp_t snap(string tag);
    exp_t e;
    for (int i = 0; i < NCH; i++) e.codes[i*DW +: DW] = model[i];
    e.osc = model_osc;
    e.ovr = (model[12] == 10'h2A0);
    e.tag = tag;
    return e;
  endfunction

  function automatic logic [16:0] mk(logic t, logic o, int a, logic [9:0] d);
    return {t, o, 5'(a), d};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // bits[n-1] goes out first
  task automatic send(logic [31:0] bits, int n, string tag);
    logic [16:0] w;
    latch_in = 1'b0; tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdin_in = bits[i]; tick(4);
      sclk_in = 1'b1;    tick(4);
      sclk_in = 1'b0;
    end
    tick(4);
    q.push_back(snap({tag, " before strobe R3"}));
    tick(4);
    latch_in = 1'b1; tick(12);
    if (n >= 17) begin
      w = bits[16:0];
      if (!w[16] && int'(w[14:10]) <= 12) begin
        model[int'(w[14:10])] = w[9:0];
        model_osc = w[15];
      end
    end
    q.push_back(snap(tag));
    tick(4);
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (chan_codes_o !== e.codes || ext_osc_o !== e.osc || override_o !== e.ovr) begin
          fails++;
          $display("FAIL %s: actual codes=%h osc=%b ovr=%b expected codes=%h osc=%b ovr=%b",
                   e.tag, chan_codes_o, ext_osc_o, override_o, e.codes, e.osc, e.ovr);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < 13; i++) model[i] = '0;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    q.push_back(snap("R1 reset state"));
    tick(3);

    send(32'(mk(0, 0, 0, 10'h3FF)), 17, "R2 write ch0");
    send(32'(mk(0, 0, 5, 10'h155)), 17, "R2 write ch5");
    send(32'(mk(0, 0, 11, 10'h2AA)), 17, "R2 write ch11");
    send(32'(mk(0, 0, 3, 10'h123) >> 1), 16, "R4 short frame");
    send(32'(mk(0, 0, 4, 10'h001)), 1, "R4 single bit");
    send({12'h0, 3'b111, mk(0, 0, 7, 10'h0AB)}, 20, "R5 long frame");
    send(32'(mk(0, 1, 1, 10'h200)), 17, "R6 osc external");
    send(32'(mk(1, 0, 2, 10'h1FF)), 17, "R7 test bit set");
    send(32'(mk(0, 0, 1, 10'h011)), 17, "R6 osc internal");
    send(32'(mk(0, 1, 13, 10'h3AA)), 17, "R8 address 13");
    send(32'(mk(0, 1, 31, 10'h0F0)), 17, "R8 address 31");
    send(32'(mk(0, 0, 12, 10'h2A0)), 17, "R9 override set");
    send(32'(mk(0, 0, 12, 10'h2A1)), 17, "R9 override clear");
    send(32'(mk(0, 0, 12, 10'h2A0)), 17, "R9 override again");
    send(32'(mk(0, 0, 12, 10'h000)), 17, "R9 override zero");

    while (q.size() > 0) tick(1);
    tick(2);
    finish_up();
  end
endmodule